// File: doc/BRIEF.md
# Load-reserved / store-conditional unit

This block executes load-reserved (LR) and store-conditional (SC) operations for a processor pipeline. It accepts one operation at a time, carrying an address that has already been relocated and translated, a width code, store data, and acquire/release ordering bits. It runs the operation against a simple request/response memory port and returns either a destination-register value or an exception cause.

The block holds one reservation: a valid flag, the reserved address and the reserved width. An LR that completes sets the reservation. An SC checks the reservation before it touches memory. If the check passes, the SC announces its effective address, then writes its data. It returns 0 when memory takes the write and 1 when memory declines it, and the reservation is dropped in both cases. An SC that finds no matching reservation returns 1 at once. The only external event that invalidates the reservation is `resv_clear`.

Memory protocol: `mem_req_valid` stays high for the whole of a phase. The phase ends in the first cycle `mem_resp_valid` is high, and memory answers one or more cycles after the request appears. `mem_op` is 0 for a read, 1 for the address announcement and 2 for the data write. For a word read, memory returns the word in `mem_rdata[31:0]`.

Top module: `lrsc_unit`

## Requirements
- R1: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` is high only while no operation is in progress.
- R2: Only width codes 2 (word, 4 bytes) and 3 (double, 8 bytes) are legal. Codes 0 and 1 end with exception cause 2 and make no memory access.
- R3: A word is aligned when address bits 1:0 are zero, and a double is aligned when bits 2:0 are zero. A misaligned LR ends with exception cause 4 (load address misaligned) and makes no memory access.
- R4: A misaligned SC ends with exception cause 6 (store/AMO address misaligned) and makes no memory access. Alignment is checked before the reservation, so a misaligned SC leaves the reservation unchanged.
- R5: An LR makes one read (`mem_op`=0). It returns the full double, or the word sign-extended from bit 31. It then records its address and width as the reservation.
- R6: An SC matches only when the reservation is valid and both its address and its width equal the reserved ones. Without a match it returns 1 and makes no memory access.
- R7: A matching SC issues an address phase (`mem_op`=1), then a data phase (`mem_op`=2). For a word it sends only the low 32 bits of the store data, with the upper bits zero.
- R8: If memory accepts the SC write (`mem_resp_ok`=1), the result is 0. If memory declines it, the result is 1. The reservation is cleared in both cases.
- R9: A memory error in any phase ends the operation with `done_exc` high and the cause taken from `mem_resp_cause`, and no destination value is reported. A failed LR sets no reservation, and a failed SC keeps it.
- R10: `resv_clear` invalidates the reservation, so a following SC returns 1.
- R11: `done_valid` pulses for exactly one cycle per accepted request. After reset the unit is ready, holds no reservation, and drives no memory request and no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation request |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_sc | input | 1 | 1 = store-conditional, 0 = load-reserved |
| req_width | input | 2 | 0 byte, 1 half, 2 word, 3 double |
| req_addr | input | XLEN | Translated address |
| req_wdata | input | XLEN | SC store data |
| req_aq | input | 1 | Acquire ordering bit |
| req_rl | input | 1 | Release ordering bit |
| resv_clear | input | 1 | External reservation invalidate |
| mem_req_valid | output | 1 | Memory phase active |
| mem_op | output | 2 | 0 read, 1 address announce, 2 write |
| mem_addr | output | XLEN | Access address |
| mem_wdata | output | XLEN | Write data |
| mem_dbl | output | 1 | 1 = 8-byte access, 0 = 4-byte |
| mem_aq | output | 1 | Acquire bit for the access |
| mem_rl | output | 1 | Release bit for the access |
| mem_resp_valid | input | 1 | Phase response |
| mem_resp_err | input | 1 | Phase raised an exception |
| mem_resp_ok | input | 1 | Write accepted (data phase) |
| mem_resp_cause | input | CW | Exception cause of a failed phase |
| mem_rdata | input | XLEN | Read data |
| done_valid | output | 1 | Operation complete |
| done_exc | output | 1 | Operation ended in an exception |
| done_cause | output | CW | Exception cause |
| done_rd | output | XLEN | Destination value when no exception |

## Verification
The sweep crosses every width code with every low-order offset, for both LR and SC. A unit that checked the wrong address bits, or swapped the load and store misalignment causes, would report the wrong cause or start a memory access. Directed sequences test reservation matching: an SC that differs only in width or in address must fail without an access, while a misaligned SC between an LR and its SC must leave the reservation usable. A unit that dropped it there would fail the later SC. A declined write followed by a second SC shows whether the reservation is cancelled. Faults in each phase show whether the result is suppressed, and a faulting LR that still set the reservation would let a later SC write.

// File: rtl/lrsc_unit.sv
module lrsc_unit #(
  parameter int XLEN = 64,
  parameter int CW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_sc,
  input  logic [1:0]      req_width,
  input  logic [XLEN-1:0] req_addr,
  input  logic [XLEN-1:0] req_wdata,
  input  logic            req_aq,
  input  logic            req_rl,
  input  logic            resv_clear,
  output logic            mem_req_valid,
  output logic [1:0]      mem_op,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            mem_dbl,
  output logic            mem_aq,
  output logic            mem_rl,
  input  logic            mem_resp_valid,
  input  logic            mem_resp_err,
  input  logic            mem_resp_ok,
  input  logic [CW-1:0]   mem_resp_cause,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            done_valid,
  output logic            done_exc,
  output logic [CW-1:0]   done_cause,
  output logic [XLEN-1:0] done_rd
);

  localparam logic [CW-1:0] C_ILLEGAL  = CW'(2);
  localparam logic [CW-1:0] C_LD_ALIGN = CW'(4);
  localparam logic [CW-1:0] C_ST_ALIGN = CW'(6);
  localparam logic [1:0] OP_RD = 2'd0;
  localparam logic [1:0] OP_EA = 2'd1;
  localparam logic [1:0] OP_WR = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_EA, S_WR} st_t;
  st_t st;

  logic [XLEN-1:0] a_q, d_q;
  logic            dbl_q, aq_q, rl_q;
  logic            rv, rdbl;
  logic [XLEN-1:0] ra;

  wire accept = req_valid && (st == S_IDLE);
  wire legal  = req_width[1];
  wire misal  = req_width[0] ? (req_addr[2:0] != 3'b000) : (req_addr[1:0] != 2'b00);
  wire hit    = rv && (ra == req_addr) && (rdbl == req_width[0]);
  wire ok_rsp = mem_resp_valid && !mem_resp_err;
  wire [XLEN-1:0] ld_val = dbl_q ? mem_rdata
                                 : {{(XLEN-32){mem_rdata[31]}}, mem_rdata[31:0]};

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st != S_IDLE);
  assign mem_op        = (st == S_WR) ? OP_WR : (st == S_EA) ? OP_EA : OP_RD;
  assign mem_addr      = a_q;
  assign mem_wdata     = dbl_q ? d_q : {{(XLEN-32){1'b0}}, d_q[31:0]};
  assign mem_dbl       = dbl_q;
  assign mem_aq        = aq_q;
  assign mem_rl        = rl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv   <= 1'b0;
      rdbl <= 1'b0;
      ra   <= '0;
    end else if (resv_clear) begin
      rv <= 1'b0;
    end else if (st == S_RD && ok_rsp) begin
      rv   <= 1'b1;
      ra   <= a_q;
      rdbl <= dbl_q;
    end else if (st == S_WR && ok_rsp) begin
      rv <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      a_q        <= '0;
      d_q        <= '0;
      dbl_q      <= 1'b0;
      aq_q       <= 1'b0;
      rl_q       <= 1'b0;
      done_valid <= 1'b0;
      done_exc   <= 1'b0;
      done_cause <= '0;
      done_rd    <= '0;
    end else begin
      done_valid <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          a_q   <= req_addr;
          d_q   <= req_wdata;
          dbl_q <= req_width[0];
          aq_q  <= req_aq;
          rl_q  <= req_rl;
          if (!legal) begin
            done_valid <= 1'b1;
            done_exc   <= 1'b1;
            done_cause <= C_ILLEGAL;
          end else if (misal) begin
            done_valid <= 1'b1;
            done_exc   <= 1'b1;
            done_cause <= req_sc ? C_ST_ALIGN : C_LD_ALIGN;
          end else if (!req_sc) begin
            st <= S_RD;
          end else if (!hit) begin
            done_valid <= 1'b1;
            done_exc   <= 1'b0;
            done_rd    <= XLEN'(1);
          end else begin
            st <= S_EA;
          end
        end
        S_RD: if (mem_resp_valid) begin
          st         <= S_IDLE;
          done_valid <= 1'b1;
          done_exc   <= mem_resp_err;
          done_cause <= mem_resp_cause;
          if (!mem_resp_err) done_rd <= ld_val;
        end
        S_EA: if (mem_resp_valid) begin
          if (mem_resp_err) begin
            st         <= S_IDLE;
            done_valid <= 1'b1;
            done_exc   <= 1'b1;
            done_cause <= mem_resp_cause;
          end else begin
            st <= S_WR;
          end
        end
        default: if (mem_resp_valid) begin
          st         <= S_IDLE;
          done_valid <= 1'b1;
          done_exc   <= mem_resp_err;
          done_cause <= mem_resp_cause;
          if (!mem_resp_err) done_rd <= mem_resp_ok ? XLEN'(0) : XLEN'(1);
        end
      endcase
    end
  end

  // R1
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R2
  illegal_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_width[1]) |=> (done_valid && done_exc && done_cause == C_ILLEGAL && !mem_req_valid));

  // R3
  ld_misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_sc && req_width == 2'd3 && req_addr[2:0] != 3'b000)
      |=> (done_exc && done_cause == C_LD_ALIGN && !mem_req_valid));

  // R4
  st_misalign_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_sc && legal && misal && !resv_clear) |=> $stable(rv));

  // R6
  sc_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_sc && legal && !misal && !rv) |=> (done_valid && !done_exc && done_rd == XLEN'(1) && !mem_req_valid));

  // R7
  wr_after_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_op == OP_WR) |-> $past(mem_req_valid && (mem_op == OP_EA || mem_op == OP_WR)));

  // R7
  word_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_op == OP_WR && !mem_dbl) |-> (mem_wdata[XLEN-1:32] == '0));

  // R10
  clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resv_clear |=> !rv);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

endmodule

// File: tb/lrsc_unit_bench.sv
module lrsc_unit_bench;
  localparam int XLEN = 64;
  localparam int CW   = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic req_valid = 0, req_sc = 0, req_aq = 0, req_rl = 0, resv_clear = 0;
  logic [1:0] req_width = 0;
  logic [XLEN-1:0] req_addr = 0, req_wdata = 0;
  logic req_ready, mem_req_valid, mem_dbl, mem_aq, mem_rl;
  logic [1:0] mem_op;
  logic [XLEN-1:0] mem_addr, mem_wdata;
  logic mem_resp_valid, mem_resp_err, mem_resp_ok;
  logic [CW-1:0] mem_resp_cause;
  logic [XLEN-1:0] mem_rdata;
  logic done_valid, done_exc;
  logic [CW-1:0] done_cause;
  logic [XLEN-1:0] done_rd;

  lrsc_unit #(.XLEN(XLEN), .CW(CW)) u_lrsc_unit (.*);

  logic [63:0] mem [0:7];
  int acc_cnt;
  logic f_rd = 0, f_ea = 0, f_wr = 0, decline = 0;

  function automatic logic [63:0] pat(int i);
    return {32'h8000_0000 | (32'h1111 * i), 32'h0000_1000 + i};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) mem[i] <= pat(i);
      acc_cnt <= 0;
      mem_resp_valid <= 0; mem_resp_err <= 0; mem_resp_ok <= 0;
      mem_resp_cause <= 0; mem_rdata <= 0;
    end else if (mem_resp_valid) begin
      mem_resp_valid <= 0;
    end else if (mem_req_valid) begin
      acc_cnt <= acc_cnt + 1;
      mem_resp_valid <= 1; mem_resp_err <= 0; mem_resp_ok <= 0;
      case (mem_op)
        2'd0: if (f_rd) begin mem_resp_err <= 1; mem_resp_cause <= 5'd13; end
              else mem_rdata <= mem_dbl ? mem[mem_addr[5:3]]
                    : {32'h0, mem_addr[2] ? mem[mem_addr[5:3]][63:32] : mem[mem_addr[5:3]][31:0]};
        2'd1: if (f_ea) begin mem_resp_err <= 1; mem_resp_cause <= 5'd7; end
        default: if (f_wr) begin mem_resp_err <= 1; mem_resp_cause <= 5'd15; end
          else if (!decline) begin
            mem_resp_ok <= 1;
            if (mem_dbl) mem[mem_addr[5:3]] <= mem_wdata;
            else if (mem_addr[2]) mem[mem_addr[5:3]][63:32] <= mem_wdata[31:0];
            else mem[mem_addr[5:3]][31:0] <= mem_wdata[31:0];
          end
      endcase
    end
  end

  int n_chk = 0, n_bad = 0;
  logic o_exc; logic [CW-1:0] o_cause; logic [XLEN-1:0] o_rd; int o_acc;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(logic sc, logic [1:0] w, logic [63:0] a, logic [63:0] d);
    int a0;
    @(negedge clk);
    a0 = acc_cnt;
    req_valid = 1; req_sc = sc; req_width = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    while (!done_valid) @(negedge clk);
    o_exc = done_exc; o_cause = done_cause; o_rd = done_rd; o_acc = acc_cnt - a0;
  endtask

  task automatic clr();
    @(negedge clk); resv_clear = 1; @(negedge clk); resv_clear = 0;
  endtask

  function automatic logic [63:0] ld_exp(logic [1:0] w, logic [63:0] a);
    logic [31:0] wd;
    if (w == 2'd3) return mem[a[5:3]];
    wd = a[2] ? mem[a[5:3]][63:32] : mem[a[5:3]][31:0];
    return {{32{wd[31]}}, wd};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] e, snap;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check("R11 ready", req_ready, 1);
    check("R11 done", done_valid, 0);
    check("R11 memreq", mem_req_valid, 0);

    for (int sc = 0; sc < 2; sc++)
      for (int w = 0; w < 4; w++)
        for (int off = 0; off < 8; off++) begin
          logic [63:0] a;
          a = 64'h48 + off;
          clr();
          e = ld_exp(2'(w), a);
          run(sc[0], 2'(w), a, 64'hAAAA_BBBB_CCCC_DDDD);
          if (w < 2) begin
            check("R2 cause", {o_exc, o_cause}, {1'b1, 5'd2});
            check("R2 noacc", o_acc, 0);
          end else if ((w == 2 && off[1:0] != 0) || (w == 3 && off != 0)) begin
            if (sc) check("R4 cause", {o_exc, o_cause}, {1'b1, 5'd6});
            else    check("R3 cause", {o_exc, o_cause}, {1'b1, 5'd4});
            check("R3 R4 noacc", o_acc, 0);
          end else if (!sc) begin
            check("R5 value", {o_exc, o_rd}, {1'b0, e});
            check("R5 acc", o_acc, 1);
          end else begin
            check("R6 noresv", {o_exc, o_rd}, {1'b0, 64'd1});
            check("R6 noacc", o_acc, 0);
          end
        end

    // R4: misaligned SC leaves reservation; R7/R8 word success
    run(0, 2'd2, 64'h54, 0);
    run(1, 2'd2, 64'h56, 64'h1);
    check("R4 cause order", {o_exc, o_cause}, {1'b1, 5'd6});
    snap = mem[2];
    run(1, 2'd2, 64'h54, 64'hFFFF_FFFF_1234_5678);
    check("R8 success", {o_exc, o_rd}, {1'b0, 64'd0});
    check("R7 phases", o_acc, 2);
    check("R7 word data", mem[2], {32'h1234_5678, snap[31:0]});
    run(1, 2'd2, 64'h54, 64'h9);
    check("R8 cancelled", {o_rd, 64'(o_acc)}, {64'd1, 64'd0});

    // R6 width and address mismatch
    run(0, 2'd3, 64'h58, 0);
    run(1, 2'd2, 64'h58, 64'h5);
    check("R6 width mismatch", {o_rd, 64'(o_acc)}, {64'd1, 64'd0});
    run(1, 2'd3, 64'h60, 64'h5);
    check("R6 addr mismatch", {o_rd, 64'(o_acc)}, {64'd1, 64'd0});

    // R10
    clr();
    run(1, 2'd3, 64'h58, 64'h5);
    check("R10 clear", {o_rd, 64'(o_acc)}, {64'd1, 64'd0});

    // R8 decline
    run(0, 2'd3, 64'h58, 0);
    decline = 1; snap = mem[3];
    run(1, 2'd3, 64'h58, 64'h77);
    decline = 0;
    check("R8 decline", {o_exc, o_rd}, {1'b0, 64'd1});
    check("R8 decline mem", mem[3], snap);
    run(1, 2'd3, 64'h58, 64'h77);
    check("R8 decline cancels", {o_rd, 64'(o_acc)}, {64'd1, 64'd0});

    // R9 address phase fault keeps reservation
    run(0, 2'd3, 64'h58, 0);
    f_ea = 1;
    run(1, 2'd3, 64'h58, 64'h77);
    f_ea = 0;
    check("R9 ea fault", {o_exc, o_cause, 8'(o_acc)}, {1'b1, 5'd7, 8'd1});
    run(1, 2'd3, 64'h58, 64'hDEAD_BEEF_0000_0001);
    check("R9 resv kept", {o_exc, o_rd}, {1'b0, 64'd0});
    check("R7 dbl data", mem[3], 64'hDEAD_BEEF_0000_0001);

    // R9 data phase fault
    run(0, 2'd3, 64'h58, 0);
    f_wr = 1;
    run(1, 2'd3, 64'h58, 64'h1);
    f_wr = 0;
    check("R9 wr fault", {o_exc, o_cause, 8'(o_acc)}, {1'b1, 5'd15, 8'd2});

    // R9 read fault sets no reservation
    clr();
    f_rd = 1;
    run(0, 2'd3, 64'h40, 0);
    f_rd = 0;
    check("R9 rd fault", {o_exc, o_cause}, {1'b1, 5'd13});
    run(1, 2'd3, 64'h40, 64'h3);
    check("R9 no resv", {o_rd, 64'(o_acc)}, {64'd1, 64'd0});

    // R1/R11 idle again, single pulse
    @(negedge clk);
    check("R1 ready after", req_ready, 1);
    check("R11 pulse", done_valid, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule